// File: doc/BRIEF.md
# Protection region address matcher

The block decides whether one memory access may proceed. It holds eight protection regions. Each region is set by its own 32-bit word, which gives an enable bit, a power-of-two size exponent and an aligned base. From each word the block derives a compare mask and a compare value and keeps them in registers. These registers are refreshed only when a recompute strobe arrives. The check of an incoming address then needs only an AND and an equality test per region.

The regions that match are resolved by priority: the highest-numbered matching region wins. The 4-bit permission code of the winning region is taken from the data permission word for reads and writes, and from the instruction permission word for execution. That code, together with the current privilege level, produces three grant outputs. A per-region hit vector is also brought out. The register bank that stores the words and the fault signalling towards the processor sit outside this block.

Top module: `prot_region_matcher`

## Requirements
- R1: After reset, every region behaves as disabled until the first recompute strobe: `hit_o` is all zero and all three grant outputs are low.
- R2: A region whose configuration word has bit 0 clear never matches any address, whatever its other bits hold.
- R3: For an enabled region with size code N = word[5:1] and N below 31, the region spans 2^(N+1) bytes, with a minimum granularity of 64 bytes. The address hits when (address AND M) equals (word AND M), where M = NOT((2^(N+1) − 1) OR 0x3F).
- R4: An enabled region with size code 31 matches every 32-bit address.
- R5: Masks and compare values are loaded from `region_cfg_i` on the clock edge at which `recalc_i` is high. They take effect from the next cycle. A change of `region_cfg_i` without the strobe has no effect on `hit_o` or the grants.
- R6: Bit n of `hit_o` is high exactly when region n matches the current `addr_i` under its last recomputed mask and value. This output is combinational from `addr_i`.
- R7: When several regions match, only the highest-numbered matching region supplies the permission code.
- R8: When no region matches, reads, writes and execution are all denied.
- R9: The permission code of region n is bits [4n+3:4n] of the permission word. Codes have these meanings:
  - 0: no access.
  - 1: privileged read/write only.
  - 2: privileged read/write, user read-only.
  - 3: read/write for both levels.
  - 5: privileged read-only.
  - 6: read-only for both levels.
- R10: Codes 4, 7, 8 and every code from 9 to 15 deny all access at both privilege levels.
- R11: Read and write grants use the code from `data_perm_i`. The execute grant uses the code from `inst_perm_i` and is high exactly when that code would grant a read at the current privilege level (`priv_i` high = privileged).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| recalc_i | input | 1 | Recompute strobe; latches masks and values from region_cfg_i |
| region_cfg_i | input | 256 | Eight configuration words, region n in bits [32n+31:32n] |
| data_perm_i | input | 32 | Data permission codes, 4 bits per region |
| inst_perm_i | input | 32 | Instruction permission codes, 4 bits per region |
| addr_i | input | 32 | Address under check |
| priv_i | input | 1 | 1 = privileged access, 0 = user access |
| hit_o | output | 8 | Per-region match vector |
| rd_allow_o | output | 1 | Read permitted |
| wr_allow_o | output | 1 | Write permitted |
| ex_allow_o | output | 1 | Execute permitted |

## Verification
The assertions take `recalc_i` to be a clean single-bit strobe and `addr_i` to be held steady between bench updates. Their stability check relates `hit_o` to the previous cycle, so it counts only when the address and strobe did not move. The stimulus changes addresses and configuration only at falling edges. It raises the strobe for one cycle at a time, and it draws addresses both inside generated regions and at random, so that overlaps, the full-space code and disabled regions all occur.

// File: rtl/prot_match_pkg.sv
package prot_match_pkg;
  localparam int unsigned NUM_REGIONS = 8;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned CODE_W      = 4;
  localparam int unsigned SIZE_W      = 5;
  localparam int unsigned GRAN_BITS   = 6;   // 64-byte minimum granularity
  localparam int unsigned IDX_W       = $clog2(NUM_REGIONS);

  typedef struct packed {
    logic rd;
    logic wr;
  } grant_t;

  function automatic grant_t code_grant(logic [CODE_W-1:0] code, logic priv);
    grant_t g;
    g = '0;
    case (code)
      4'd1: begin g.rd = priv; g.wr = priv; end
      4'd2: begin g.rd = 1'b1; g.wr = priv; end
      4'd3: begin g.rd = 1'b1; g.wr = 1'b1; end
      4'd5: begin g.rd = priv; end
      4'd6: begin g.rd = 1'b1; end
      default: g = '0;  // 0, unpredictable and reserved codes
    endcase
    return g;
  endfunction
endpackage

// File: rtl/prot_region_cfg.sv
module prot_region_cfg
  import prot_match_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          recalc_i,
  input  logic [AW-1:0] word_i,
  output logic [AW-1:0] mask_o,
  output logic [AW-1:0] value_o
);
  localparam logic [SIZE_W-1:0] FULL_CODE = '1;

  logic              en;
  logic [SIZE_W-1:0] size_code;
  logic [AW-1:0]     span_m1;
  logic [AW-1:0]     mask_d, value_d;

  assign en        = word_i[0];
  assign size_code = word_i[SIZE_W:1];

  always_comb begin
    span_m1 = (AW'(1) << ({1'b0, size_code} + (SIZE_W+1)'(1))) - AW'(1);
    if (!en) begin
      mask_d  = '0;
      value_d = '1;                 // unreachable compare value
    end else if (size_code == FULL_CODE) begin
      mask_d  = '0;                 // whole space, avoids wraparound
      value_d = '0;
    end else begin
      mask_d  = ~(span_m1 | AW'((1 << GRAN_BITS) - 1));
      value_d = word_i & mask_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o  <= '0;
      value_o <= '1;
    end else if (recalc_i) begin
      mask_o  <= mask_d;
      value_o <= value_d;
    end
  end
endmodule

// File: rtl/prot_region_cmp.sv
module prot_region_cmp
  import prot_match_pkg::*;
#(
  parameter int unsigned NR = NUM_REGIONS,
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [NR*AW-1:0] mask_i,
  input  logic [NR*AW-1:0] value_i,
  output logic [NR-1:0]    hit_o
);
  for (genvar n = 0; n < NR; n++) begin : g_cmp
    assign hit_o[n] = (addr_i & mask_i[n*AW +: AW]) == value_i[n*AW +: AW];
  end
endmodule

// File: rtl/prot_perm_arb.sv
module prot_perm_arb
  import prot_match_pkg::*;
#(
  parameter int unsigned NR = NUM_REGIONS
) (
  input  logic [NR-1:0]        hit_i,
  input  logic [NR*CODE_W-1:0] data_perm_i,
  input  logic [NR*CODE_W-1:0] inst_perm_i,
  input  logic                 priv_i,
  output logic                 rd_allow_o,
  output logic                 wr_allow_o,
  output logic                 ex_allow_o
);
  localparam int unsigned SW = (NR > 1) ? $clog2(NR) : 1;

  logic [SW-1:0]     sel;
  logic              any;
  logic [CODE_W-1:0] dcode, icode;
  grant_t            dg, ig;

  // later index overrides earlier: highest-numbered hit wins
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int n = 0; n < NR; n++) begin
      if (hit_i[n]) begin
        sel = SW'(n);
        any = 1'b1;
      end
    end
  end

  assign dcode = data_perm_i[sel*CODE_W +: CODE_W];
  assign icode = inst_perm_i[sel*CODE_W +: CODE_W];
  assign dg    = code_grant(dcode, priv_i);
  assign ig    = code_grant(icode, priv_i);

  assign rd_allow_o = any & dg.rd;
  assign wr_allow_o = any & dg.wr;
  assign ex_allow_o = any & ig.rd;
endmodule

// File: rtl/prot_region_matcher.sv
module prot_region_matcher
  import prot_match_pkg::*;
#(
  parameter int unsigned NR = NUM_REGIONS,
  parameter int unsigned AW = ADDR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 recalc_i,
  input  logic [NR*AW-1:0]     region_cfg_i,
  input  logic [NR*CODE_W-1:0] data_perm_i,
  input  logic [NR*CODE_W-1:0] inst_perm_i,
  input  logic [AW-1:0]        addr_i,
  input  logic                 priv_i,
  output logic [NR-1:0]        hit_o,
  output logic                 rd_allow_o,
  output logic                 wr_allow_o,
  output logic                 ex_allow_o
);
  logic [NR*AW-1:0] mask_q, value_q;

  for (genvar n = 0; n < NR; n++) begin : g_cfg
    prot_region_cfg #(.AW(AW)) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .recalc_i(recalc_i),
      .word_i  (region_cfg_i[n*AW +: AW]),
      .mask_o  (mask_q[n*AW +: AW]),
      .value_o (value_q[n*AW +: AW])
    );
  end

  prot_region_cmp #(.NR(NR), .AW(AW)) u_cmp (
    .addr_i (addr_i),
    .mask_i (mask_q),
    .value_i(value_q),
    .hit_o  (hit_o)
  );

  prot_perm_arb #(.NR(NR)) u_arb (
    .hit_i      (hit_o),
    .data_perm_i(data_perm_i),
    .inst_perm_i(inst_perm_i),
    .priv_i     (priv_i),
    .rd_allow_o (rd_allow_o),
    .wr_allow_o (wr_allow_o),
    .ex_allow_o (ex_allow_o)
  );
endmodule

// File: rtl/prot_region_matcher_chk.sv
module prot_region_matcher_chk
  import prot_match_pkg::*;
#(
  parameter int unsigned NR = NUM_REGIONS,
  parameter int unsigned AW = ADDR_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             recalc_i,
  input logic [NR*AW-1:0] region_cfg_i,
  input logic [AW-1:0]    addr_i,
  input logic [NR-1:0]    hit_o,
  input logic             rd_allow_o,
  input logic             wr_allow_o,
  input logic             ex_allow_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r8_no_hit_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o == '0) |-> (!rd_allow_o && !wr_allow_o && !ex_allow_o));

  a_r9_write_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_allow_o |-> rd_allow_o);

  a_r5_hold_without_recalc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(recalc_i) && $stable(addr_i)) |-> $stable(hit_o));

  for (genvar n = 0; n < NR; n++) begin : g_reg
    a_r2_disabled_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && $past(recalc_i) && !$past(region_cfg_i[n*AW])) |-> !hit_o[n]);

    a_r4_full_space_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && $past(recalc_i) && ($past(region_cfg_i[n*AW +: 6]) == 6'h3F))
        |-> hit_o[n]);
  end
endmodule

bind prot_region_matcher prot_region_matcher_chk #(.NR(NR), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .recalc_i    (recalc_i),
  .region_cfg_i(region_cfg_i),
  .addr_i      (addr_i),
  .hit_o       (hit_o),
  .rd_allow_o  (rd_allow_o),
  .wr_allow_o  (wr_allow_o),
  .ex_allow_o  (ex_allow_o)
);

// File: tb/prot_region_matcher_tb_top.sv
module prot_region_matcher_tb_top;
  localparam int NR = 8;
  localparam int AW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            recalc = 1'b0;
  logic [NR*AW-1:0] cfg = '0;
  logic [31:0]     dperm = '0, iperm = '0;
  logic [31:0]     addr = '0;
  logic            priv = 1'b0;
  logic [NR-1:0]   hit;
  logic            rd, wr, ex;

  int n_chk = 0, n_bad = 0;
  logic [31:0] model_cfg [NR];   // words as last latched by a strobe
  bit model_valid = 1'b0;        // 0 = reset state, all disabled

  always #5 clk = ~clk;

  prot_region_matcher dut_i (
    .clk_i(clk), .rst_ni(rst_n), .recalc_i(recalc), .region_cfg_i(cfg),
    .data_perm_i(dperm), .inst_perm_i(iperm), .addr_i(addr), .priv_i(priv),
    .hit_o(hit), .rd_allow_o(rd), .wr_allow_o(wr), .ex_allow_o(ex)
  );

  function automatic bit exp_hit1(logic [31:0] w, logic [31:0] a);
    logic [31:0] m;
    if (!w[0]) return 1'b0;
    if (w[5:1] == 5'd31) return 1'b1;
    m = ~(((32'd1 << (w[5:1] + 1)) - 32'd1) | 32'h3F);
    return (a & m) == (w & m);
  endfunction

  function automatic logic [NR-1:0] exp_hits(logic [31:0] a);
    logic [NR-1:0] h = '0;
    if (model_valid)
      for (int n = 0; n < NR; n++) h[n] = exp_hit1(model_cfg[n], a);
    return h;
  endfunction

  // returns {read, write}
  function automatic logic [1:0] exp_grant(logic [3:0] c, logic p);
    case (c)
      4'd0: return 2'b00;
      4'd1: return p ? 2'b11 : 2'b00;
      4'd2: return p ? 2'b11 : 2'b10;
      4'd3: return 2'b11;
      4'd5: return p ? 2'b10 : 2'b00;
      4'd6: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(string req);
    logic [NR-1:0] eh;
    logic [2:0] eg, ag;
    int top;
    eh = exp_hits(addr);
    top = -1;
    for (int n = 0; n < NR; n++) if (eh[n]) top = n;
    eg = 3'b000;
    if (top >= 0) begin
      eg[2:1] = exp_grant(dperm[top*4 +: 4], priv);
      eg[0]   = exp_grant(iperm[top*4 +: 4], priv)[1];
    end
    ag = {rd, wr, ex};
    n_chk++;
    if (hit !== eh || ag !== eg) begin
      n_bad++;
      $display("FAIL %s addr=%h priv=%0d hit=%b/%b rwx=%b/%b (actual/expected)",
               req, addr, priv, hit, eh, ag, eg);
    end
  endtask

  task automatic load_cfg();
    @(negedge clk); recalc = 1'b1;
    @(negedge clk); recalc = 1'b0;
    for (int n = 0; n < NR; n++) model_cfg[n] = cfg[n*AW +: AW];
    model_valid = 1'b1;
  endtask

  task automatic probe(logic [31:0] a, logic p, string req);
    @(negedge clk); addr = a; priv = p;
    #1 check(req);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] w;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    dperm = 32'h3333_3333; iperm = 32'h3333_3333;
    probe(32'h0, 1'b1, "R1 reset");
    rst_n = 1'b1;
    probe(32'h1234_5678, 1'b1, "R1 reset");
    probe(32'hFFFF_FFC0, 1'b0, "R1 reset");

    // R4 full-space in region 0, R3 64-byte region 3 at 0x1000
    cfg = '0;
    cfg[0*AW +: AW] = {26'h0, 5'd31, 1'b1};
    cfg[3*AW +: AW] = 32'h0000_1000 | {26'h0, 5'd2, 1'b1};
    load_cfg();
    probe(32'hDEAD_BEEF, 1'b0, "R4 full space");
    probe(32'h0000_103F, 1'b1, "R3 R7 inside small region");
    probe(32'h0000_1040, 1'b1, "R3 just past region");
    probe(32'h0000_0FFF, 1'b1, "R3 just below region");

    // R5: change cfg without strobe
    cfg[3*AW +: AW] = 32'h0;
    cfg[0*AW +: AW] = 32'h0;
    probe(32'h0000_1000, 1'b1, "R5 no strobe no effect");
    probe(32'h8000_0000, 1'b0, "R5 no strobe no effect");
    load_cfg();
    probe(32'h0000_1000, 1'b1, "R2 R8 all disabled");

    // R2: disabled region with full-space code
    cfg[5*AW +: AW] = {26'h3FF_FFFF, 5'd31, 1'b0};
    load_cfg();
    probe(32'h0000_0000, 1'b1, "R2 disabled full code");

    // R7 priority with overlap, R9 R10 R11 code sweep
    cfg = '0;
    cfg[1*AW +: AW] = {26'h0, 5'd31, 1'b1};
    cfg[6*AW +: AW] = 32'h4000_0000 | {26'h0, 5'd20, 1'b1};
    load_cfg();
    for (int c = 0; c < 16; c++) begin
      dperm = '0; iperm = '0;
      dperm[6*4 +: 4] = 4'(c); iperm[6*4 +: 4] = 4'(15 - c);
      dperm[1*4 +: 4] = 4'd3;  iperm[1*4 +: 4] = 4'd3;
      probe(32'h4000_0100, 1'b1, "R7 R9 R10 R11 priv codes");
      probe(32'h4010_0000, 1'b0, "R7 R9 R10 R11 user codes");
      probe(32'h1000_0000, 1'b0, "R7 lower region only");
    end

    // random mix
    for (int it = 0; it < 60; it++) begin
      for (int n = 0; n < NR; n++) begin
        w = $urandom;
        w[5:1] = ($urandom_range(0, 9) == 0) ? 5'd31 : 5'($urandom_range(0, 28));
        w[0]   = ($urandom_range(0, 3) != 0);
        cfg[n*AW +: AW] = w;
      end
      dperm = $urandom; iperm = $urandom;
      load_cfg();
      for (int k = 0; k < 20; k++) begin
        logic [31:0] a;
        int r;
        r = $urandom_range(0, NR - 1);
        a = $urandom;
        if ($urandom_range(0, 1) != 0)
          a = (model_cfg[r] & 32'hFFFF_FFC0) ^ (a & ((32'd1 << model_cfg[r][5:1]) - 1));
        probe(a, 1'($urandom_range(0, 1)), "R3 R6 R7 R9 R11 random");
      end
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule